// File: doc/BRIEF.md
# Countdown Watchdog Timer with Programmable Tick Period

This block is a watchdog timer that sits on a simple register port. It has two word registers. The control register holds an enable flag. The count register holds the number of ticks left before expiry. Once enabled, the counter loses one every tick. A tick is produced by an internal prescaler that fires once every `tick_period` system clock cycles. When the counter reaches zero, `wdt_pulse` goes high for one full tick period and then drops. After that the counter stays at zero until software writes a register again. Software services the watchdog by rewriting the count before it runs out, and it may read the remaining count at any moment.

The tick period is an input and may change while a countdown is in progress. Ticks already taken are kept, and the prescaler's progress carries over to the new period. A period of zero stops the prescaler, so the timer makes no progress and draws no switching activity until a nonzero period returns. A write to either register restarts the prescaler. A write also takes precedence over an expiry due in the same cycle. The reset input is asserted asynchronously and released in step with the clock.

Top module: `wdt_timer`

## Requirements
- R1: Register select comes from address bits [3:2] when the two low address bits are zero: word 0 is control and word 1 is count. A write to any other word, or to an address with a nonzero byte offset, changes nothing. A read of such an address returns zero.
- R2: Bit 7 of control is the enable. While it is clear, the count holds and `wdt_pulse` stays low. Control reads back the value written to it.
- R3: A write to either register while enabled, with period P ≥ 1, restarts the countdown from the current count. The first decrement comes P cycles after the write edge, and each later one comes P cycles after the one before.
- R4: Counting down from N, the count reaches zero and `wdt_pulse` rises on the same edge, N·P cycles after the arming write. The pulse stays high for P cycles and then goes low.
- R5: After an expiry the count holds at zero and no further pulse occurs until software writes a register.
- R6: Reset, whether at start-up or in the middle of a countdown, clears control and count to zero and holds `wdt_pulse` low. No countdown runs after reset is released.
- R7: A read of the count register returns the live remaining count in the same cycle.
- R8: A change of period mid-count keeps the ticks already taken, and counting continues at the new period.
- R9: A period of zero freezes the count and the prescaler with no pulse. A nonzero period resumes counting from where it stopped.
- R10: A count write on the edge where the counter would expire wins. The new value loads and no pulse is produced.
- R11: Writing a count of zero while enabled expires at the first tick, P cycles after the write.
- R12: Clearing the enable while the pulse is high drops `wdt_pulse` one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Register access strobe for this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address of the access |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the same cycle as a read strobe |
| tick_period | input | 8 | System clock cycles per tick; 0 halts the timer |
| wdt_pulse | output | 1 | Expiry pulse, high for one tick period |

## Verification
The assertions assume two things about the inputs. First, a register access lasts exactly one cycle and has stable address and data in that cycle. Second, `tick_period` changes only between clock edges. The bench drives every input on the falling edge and holds it through the next rising edge, so both assumptions hold. The bench also changes the period only at points where the expected tick schedule can be worked out from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Byte address bits below this index select a byte within a word.
  localparam int unsigned WORD_LSB = 2;
  // Control register bit that enables the countdown.
  localparam int unsigned EN_BIT = 7;
  // Word indices of the two registers.
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_COUNT = 1;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_NONE  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/wdt_reset_sync.sv
module wdt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              wr_count,
  output logic              wr_any,
  output logic [CNT_W-1:0]  load_val,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned IDX_W = ADDR_W - WORD_LSB;

  logic [IDX_W-1:0]  word_idx;
  logic              aligned;
  reg_sel_e          sel;
  logic              wr_ctrl;
  logic [DATA_W-1:0] ctrl_d;

  assign word_idx = req_addr[ADDR_W-1:WORD_LSB];
  assign aligned  = (req_addr[WORD_LSB-1:0] == '0);

  always_comb begin
    if (!aligned)                             sel = SEL_NONE;
    else if (word_idx == IDX_W'(IDX_CTRL))    sel = SEL_CTRL;
    else if (word_idx == IDX_W'(IDX_COUNT))   sel = SEL_COUNT;
    else                                      sel = SEL_NONE;
  end

  assign wr_ctrl  = req_valid && req_write && (sel == SEL_CTRL);
  assign wr_count = req_valid && req_write && (sel == SEL_COUNT);
  assign wr_any   = wr_ctrl || wr_count;
  assign load_val = req_wdata[CNT_W-1:0];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_write) begin
      case (sel)
        SEL_CTRL:  rd_data = ctrl_q;
        SEL_COUNT: rd_data = DATA_W'(cnt_live);
        default:   rd_data = '0;
      endcase
    end
  end

  // R1: control changes only on a decoded control write
  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] pre_q;
  logic [PER_W-1:0] pre_d;
  logic             per_nz;
  logic             at_end;

  assign per_nz = (period != '0);
  assign at_end = (pre_q >= (period - PER_W'(1)));
  assign tick   = run && per_nz && at_end && !restart;

  always_comb begin
    pre_d = pre_q;
    if (restart)              pre_d = '0;
    else if (run && per_nz)   pre_d = at_end ? '0 : pre_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R9: a zero period freezes the prescaler
  assert_halt_zero_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) && !restart |=> $stable(pre_q));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_any,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count_q,
  output logic             pulse_q,
  output logic             run
);
  logic [CNT_W-1:0] count_d;
  logic             armed_q;
  logic             armed_d;
  logic             pulse_d;
  logic             expire;

  assign run    = en && (armed_q || pulse_q);
  assign expire = tick && armed_q && (count_q <= CNT_W'(1));

  always_comb begin
    count_d = count_q;
    if (wr_count)                                  count_d = load_val;
    else if (tick && armed_q && count_q != '0)     count_d = count_q - CNT_W'(1);
  end

  always_comb begin
    armed_d = armed_q;
    if (wr_any)      armed_d = 1'b1;
    else if (expire) armed_d = 1'b0;
  end

  always_comb begin
    pulse_d = pulse_q;
    if (!en)                  pulse_d = 1'b0;
    else if (expire)          pulse_d = 1'b1;
    else if (tick && pulse_q) pulse_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      count_q <= count_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  // R4: the pulse only starts once the counter sits at zero
  assert_rise_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> count_q == '0);

  // R2: a disabled timer has no pulse on the following edge
  assert_no_pulse_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse_q);

  // R10: a register write never coincides with the start of a pulse
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !$rose(pulse_q));

  // R3: without a load the count only holds or steps down by one
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> (count_q == $past(count_q)) || (count_q == $past(count_q) - CNT_W'(1)));

  // R5: once disarmed the count holds until software writes
  assert_hold_after_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q && !wr_any |=> $stable(count_q));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PER_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PER_W-1:0]  tick_period,
  output logic              wdt_pulse
);
  logic              srst_n;
  logic [DATA_W-1:0] ctrl_q;
  logic              wr_count;
  logic              wr_any;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  count_q;
  logic              run;
  logic              tick;
  logic              en;

  assign en = ctrl_q[EN_BIT];

  wdt_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cnt_live  (count_q),
    .ctrl_q    (ctrl_q),
    .wr_count  (wr_count),
    .wr_any    (wr_any),
    .load_val  (load_val),
    .rd_data   (rd_data)
  );

  wdt_prescaler #(.PER_W(PER_W)) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .run     (run),
    .restart (wr_any),
    .period  (tick_period),
    .tick    (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (srst_n),
    .en       (en),
    .tick     (tick),
    .wr_count (wr_count),
    .wr_any   (wr_any),
    .load_val (load_val),
    .count_q  (count_q),
    .pulse_q  (wdt_pulse),
    .run      (run)
  );
endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [3:0]  req_addr;
  logic [15:0] req_wdata;
  logic [15:0] rd_data;
  logic [7:0]  tick_period;
  logic        wdt_pulse;

  int checks;
  int fails;

  wdt_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_data     (rd_data),
    .tick_period (tick_period),
    .wdt_pulse   (wdt_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  per;
    logic [15:0] cnt;
    logic [15:0] wait_k;
    logic [15:0] exp_cnt;
    logic        exp_pulse;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{8'd1, 16'd5,  16'd3,  16'd2, 1'b0},
    '{8'd1, 16'd5,  16'd5,  16'd0, 1'b1},
    '{8'd1, 16'd5,  16'd6,  16'd0, 1'b0},
    '{8'd3, 16'd4,  16'd7,  16'd2, 1'b0},
    '{8'd3, 16'd4,  16'd12, 16'd0, 1'b1},
    '{8'd3, 16'd4,  16'd14, 16'd0, 1'b1},
    '{8'd3, 16'd4,  16'd15, 16'd0, 1'b0},
    '{8'd2, 16'd0,  16'd1,  16'd0, 1'b0},  // R11: zero count, before first tick
    '{8'd2, 16'd0,  16'd2,  16'd0, 1'b1},  // R11: zero count expires at first tick
    '{8'd4, 16'd10, 16'd39, 16'd1, 1'b0},
    '{8'd4, 16'd10, 16'd40, 16'd0, 1'b1},
    '{8'd5, 16'd3,  16'd30, 16'd0, 1'b0}   // R5: long after expiry, no repeat
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = a;
    #1;
    d = rd_data;
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr = '0;
    req_wdata = '0;
    tick_period = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 reset state
    bus_read(4'h0, rv); check("R6 ctrl after reset", rv, 0);
    bus_read(4'h4, rv); check("R6 count after reset", rv, 0);
    check("R6 pulse after reset", wdt_pulse, 0);

    // R1 decode
    @(negedge clk);
    tick_period = 8'd1;
    bus_write(4'h4, 16'h1234);
    bus_write(4'h5, 16'h0BAD);
    bus_write(4'h8, 16'hFFFF);
    bus_write(4'h2, 16'hFFFF);
    bus_read(4'h4, rv); check("R1 count word", rv, 16'h1234);
    bus_read(4'h0, rv); check("R1 ctrl untouched", rv, 0);
    bus_read(4'h8, rv); check("R1 unmapped read", rv, 0);
    bus_read(4'h6, rv); check("R1 misaligned read", rv, 0);

    // R2 disabled: no countdown
    repeat (20) @(negedge clk);
    bus_read(4'h4, rv); check("R2 count held while disabled", rv, 16'h1234);
    check("R2 no pulse while disabled", wdt_pulse, 0);

    @(negedge clk);
    bus_write(4'h0, 16'h0080);
    bus_read(4'h0, rv); check("R2 ctrl readback", rv, 16'h0080);

    // Table: R3 R4 R7 walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      tick_period = VECS[i].per;
      bus_write(4'h4, VECS[i].cnt);
      repeat (int'(VECS[i].wait_k)) @(negedge clk);
      bus_read(4'h4, rv);
      check($sformatf("R3 R7 live count vec%0d", i), rv, VECS[i].exp_cnt);
      check($sformatf("R4 pulse vec%0d", i), wdt_pulse, VECS[i].exp_pulse);
    end

    // R9 zero period halts, nonzero resumes
    @(negedge clk);
    tick_period = 8'd2;
    bus_write(4'h4, 16'd10);
    repeat (4) @(negedge clk);
    bus_read(4'h4, rv); check("R9 count before halt", rv, 8);
    tick_period = 8'd0;
    repeat (20) @(negedge clk);
    bus_read(4'h4, rv); check("R9 count frozen", rv, 8);
    check("R9 no pulse while halted", wdt_pulse, 0);
    tick_period = 8'd2;
    @(negedge clk);
    bus_read(4'h4, rv); check("R9 resume first cycle", rv, 8);
    @(negedge clk);
    bus_read(4'h4, rv); check("R9 resume decrement", rv, 7);

    // R8 period change mid-count
    @(negedge clk);
    tick_period = 8'd4;
    bus_write(4'h4, 16'd20);
    repeat (8) @(negedge clk);
    bus_read(4'h4, rv); check("R8 count at old period", rv, 18);
    tick_period = 8'd2;
    repeat (6) @(negedge clk);
    bus_read(4'h4, rv); check("R8 count at new period", rv, 15);
    repeat (29) @(negedge clk);
    bus_read(4'h4, rv); check("R8 count before expiry", rv, 1);
    check("R8 no pulse yet", wdt_pulse, 0);
    @(negedge clk);
    bus_read(4'h4, rv); check("R8 count at expiry", rv, 0);
    check("R8 pulse at expiry", wdt_pulse, 1);

    // R10 write on expiry edge wins
    @(negedge clk);
    tick_period = 8'd1;
    bus_write(4'h4, 16'd3);
    repeat (2) @(negedge clk);
    bus_write(4'h4, 16'd7);
    bus_read(4'h4, rv); check("R10 reload wins", rv, 7);
    check("R10 no pulse", wdt_pulse, 0);
    @(negedge clk);
    bus_read(4'h4, rv); check("R10 continues", rv, 6);
    check("R10 still no pulse", wdt_pulse, 0);

    // R12 disable during pulse
    @(negedge clk);
    tick_period = 8'd3;
    bus_write(4'h4, 16'd1);
    repeat (3) @(negedge clk);
    check("R4 pulse before disable", wdt_pulse, 1);
    bus_write(4'h0, 16'h0000);
    @(negedge clk);
    check("R12 pulse dropped", wdt_pulse, 0);

    // R6 reset in the middle of a countdown
    bus_write(4'h0, 16'h0080);
    tick_period = 8'd1;
    bus_write(4'h4, 16'd50);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R6 pulse in reset", wdt_pulse, 0);
    bus_read(4'h4, rv); check("R6 count in reset", rv, 0);
    bus_read(4'h0, rv); check("R6 ctrl in reset", rv, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (14) @(negedge clk);
    bus_read(4'h4, rv); check("R6 idle after reset", rv, 0);
    check("R6 pulse idle after reset", wdt_pulse, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule